// File: doc/BRIEF.md
# Pipelined Response Validity Tracker

This block lives in a bus master whose slaves answer each command during the frame that follows it. Each outgoing frame is announced by a one-cycle start strobe together with its data length. A length of 16 means long format, and any length from 8 to 15 means short format. While a frame is on the wire, the reply bits coming back from the slave are shifted in, most significant bit first. That reply belongs to the command of the previous frame, so it is expected to carry that previous frame's data length, followed by four check bits.

When the next start strobe closes a frame, the block judges the reply it captured during that frame. A reply cannot be trusted in three cases:
- The closing frame is the first one since reset.
- The frame size changed between the previous frame and the closing frame.
- The four received check bits disagree with a serially computed 4-bit CRC.

The verdict is published as a valid flag, a reason code and the right-aligned reply data. These outputs hold until the next frame closes.

Top module: `resp_validity_tracker`

## Requirements
- R1: A frame length of 16 is long and a length of 8 to 15 is short. The reply captured during a frame is expected to hold N data bits, where N is the length of the frame before it, then 4 check bits, all sent most significant bit first on cycles where `rx_valid` is high.
- R2: The outputs change only in the cycle after a `frame_start` that closes a frame in progress, and they hold their value until the next such update. `reply_ok` is 1 exactly when `reason` is 0.
- R3: When the frame before the closing frame was short and the closing frame is long, the verdict is `reason` = 2 with `reply_ok` = 0.
- R4: When the frame before the closing frame was long and the closing frame is short, the verdict is `reason` = 3 with `reply_ok` = 0.
- R5: Reset (synchronous, active high) sets `reply_ok` = 0, `reason` = 1 and `reply_word` = 0. The first `frame_start` after reset changes none of these outputs. The frame it opens is judged with `reason` = 1 when it closes.
- R6: The check value starts at 1010. For each data bit, the top check bit is XORed with the incoming bit, the value is shifted left by one, and 0001 is XORed in when that XOR result was 1. When the four received check bits (first received bit = bit 3) differ from the computed value, the verdict is `reason` = 4. When they match and no other reason applies, the verdict is `reason` = 0.
- R7: Size-change reasons (2 and 3) take priority over a check-bit mismatch.
- R8: If fewer than N+4 reply bits arrive before the frame closes, the verdict is `reason` = 4, unless reason 1, 2 or 3 applies.
- R9: `reply_word` holds the first N reply bits, right-aligned, with zeros above them.
- R10: Reply bits that arrive after the N+4 expected bits have no effect on the verdict or on `reply_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe: closes the current frame and opens a new one |
| frame_len | input | 5 | Data length of the frame being opened (8 to 16) |
| rx_valid | input | 1 | A reply bit is present on `rx_bit` this cycle |
| rx_bit | input | 1 | Serial reply bit, most significant bit first |
| reply_ok | output | 1 | The reply of the last closed frame can be trusted |
| reason | output | 3 | 0 valid, 1 first after reset, 2 short to long, 3 long to short, 4 check mismatch or short reply |
| reply_word | output | 16 | Data bits of the last judged reply, right-aligned |

## Verification
The properties assume three things about the inputs:
- `frame_len` lies between 8 and 16 whenever `frame_start` is high.
- `rx_valid` is never high in the same cycle as `frame_start`. A bit arriving in that cycle would be dropped.
- A start strobe lasts exactly one cycle.

The stimulus keeps to these rules. Every frame is opened by a single-cycle strobe with a legal length, and reply bits are sent only in the cycles after the strobe has fallen. Within those limits the stimulus covers the following cases:
- every change of frame size;
- corrupted check bits;
- replies cut short;
- surplus trailing bits;
- a reset in the middle of traffic.

// File: rtl/rvt_pkg.sv
package rvt_pkg;

    localparam int DATA_MAX = 16;
    localparam int CRC_W    = 4;
    localparam int LEN_W    = $clog2(DATA_MAX + 1);
    localparam int CNT_W    = $clog2(DATA_MAX + CRC_W + 1);
    localparam int RSN_W    = 3;

    localparam logic [CRC_W-1:0] CRC_POLY = 4'b0001;
    localparam logic [CRC_W-1:0] CRC_SEED = 4'b1010;

    typedef enum logic [RSN_W-1:0] {
        RSN_OK     = 3'd0,
        RSN_FIRST  = 3'd1,
        RSN_GROW   = 3'd2,
        RSN_SHRINK = 3'd3,
        RSN_CRC    = 3'd4
    } reason_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             active;
    } frame_rec_t;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic [CRC_W-1:0]    crc_calc;
        logic [CRC_W-1:0]    crc_rx;
        logic [CNT_W-1:0]    count;
    } capture_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic din);
        logic                fb;
        logic [CRC_W-1:0]    nx;
        fb = c[CRC_W-1] ^ din;
        nx = {c[CRC_W-2:0], 1'b0};
        if (fb) nx = nx ^ CRC_POLY;
        return nx;
    endfunction

    function automatic logic is_long(input logic [LEN_W-1:0] len);
        return len == LEN_W'(DATA_MAX);
    endfunction

endpackage

// File: rtl/rvt_len_history.sv
module rvt_len_history
    import rvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic [LEN_W-1:0] frame_len,
    output frame_rec_t       cur,
    output frame_rec_t       prev
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '{len: LEN_W'(DATA_MAX), active: 1'b0};
            prev <= '{len: LEN_W'(DATA_MAX), active: 1'b0};
        end else if (frame_start) begin
            prev <= cur;
            cur  <= '{len: frame_len, active: 1'b1};
        end
    end

endmodule

// File: rtl/rvt_reply_capture.sv
module rvt_reply_capture
    import rvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic [LEN_W-1:0] exp_len,
    output capture_t         cap
);

    logic [CNT_W-1:0] data_end;
    logic [CNT_W-1:0] frame_end;

    assign data_end  = CNT_W'(exp_len);
    assign frame_end = CNT_W'(exp_len) + CNT_W'(CRC_W);

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            cap.data     <= '0;
            cap.crc_calc <= CRC_SEED;
            cap.crc_rx   <= '0;
            cap.count    <= '0;
        end else if (rx_valid && (cap.count < frame_end)) begin
            cap.count <= cap.count + 1'b1;
            if (cap.count < data_end) begin
                cap.data     <= {cap.data[DATA_MAX-2:0], rx_bit};
                cap.crc_calc <= crc_step(cap.crc_calc, rx_bit);
            end else begin
                cap.crc_rx <= {cap.crc_rx[CRC_W-2:0], rx_bit};
            end
        end
    end

endmodule

// File: rtl/rvt_verdict.sv
module rvt_verdict
    import rvt_pkg::*;
(
    input  frame_rec_t cur,
    input  frame_rec_t prev,
    input  capture_t   cap,
    output reason_e    verdict
);

    logic prev_long;
    logic cur_long;
    logic complete;

    assign prev_long = is_long(prev.len);
    assign cur_long  = is_long(cur.len);
    assign complete  = cap.count == (CNT_W'(prev.len) + CNT_W'(CRC_W));

    always_comb begin
        if (!prev.active)
            verdict = RSN_FIRST;
        else if (!prev_long && cur_long)
            verdict = RSN_GROW;
        else if (prev_long && !cur_long)
            verdict = RSN_SHRINK;
        else if (!complete || (cap.crc_calc != cap.crc_rx))
            verdict = RSN_CRC;
        else
            verdict = RSN_OK;
    end

endmodule

// File: rtl/resp_validity_tracker.sv
module resp_validity_tracker
    import rvt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic                rx_valid,
    input  logic                rx_bit,
    output logic                reply_ok,
    output logic [RSN_W-1:0]    reason,
    output logic [DATA_MAX-1:0] reply_word
);

    frame_rec_t cur;
    frame_rec_t prev;
    capture_t   cap;
    reason_e    verdict;

    rvt_len_history u_hist (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_len   (frame_len),
        .cur         (cur),
        .prev        (prev)
    );

    rvt_reply_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .rx_valid    (rx_valid),
        .rx_bit      (rx_bit),
        .exp_len     (prev.len),
        .cap         (cap)
    );

    rvt_verdict u_verdict (
        .cur     (cur),
        .prev    (prev),
        .cap     (cap),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reply_ok   <= 1'b0;
            reason     <= RSN_FIRST;
            reply_word <= '0;
        end else if (frame_start && cur.active) begin
            reply_ok   <= (verdict == RSN_OK);
            reason     <= verdict;
            reply_word <= cap.data;
        end
    end

endmodule

// File: rtl/rvt_checker.sv
module rvt_checker
    import rvt_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                frame_start,
    input logic [LEN_W-1:0]    frame_len,
    input logic                reply_ok,
    input logic [RSN_W-1:0]    reason,
    input logic [DATA_MAX-1:0] reply_word
);

    logic [1:0] starts;
    logic       c_cur_long;
    logic       c_prev_long;

    always_ff @(posedge clk) begin
        if (rst) begin
            starts      <= '0;
            c_cur_long  <= 1'b0;
            c_prev_long <= 1'b0;
        end else if (frame_start) begin
            if (starts != 2'd3) starts <= starts + 2'd1;
            c_cur_long  <= (frame_len == LEN_W'(DATA_MAX));
            c_prev_long <= c_cur_long;
        end
    end

    // R2
    a_r2_flag_matches_code: assert property (@(posedge clk) disable iff (rst)
        reply_ok == (reason == 3'd0));

    // R2
    a_r2_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(reason) && $stable(reply_ok) && $stable(reply_word)));

    // R5
    a_r5_first_frame_flagged: assert property (@(posedge clk) disable iff (rst)
        (frame_start && starts == 2'd1) |=> (reason == 3'd1 && !reply_ok));

    // R3
    a_r3_short_to_long: assert property (@(posedge clk) disable iff (rst)
        (frame_start && starts >= 2'd2 && !c_prev_long && c_cur_long) |=> reason == 3'd2);

    // R4
    a_r4_long_to_short: assert property (@(posedge clk) disable iff (rst)
        (frame_start && starts >= 2'd2 && c_prev_long && !c_cur_long) |=> reason == 3'd3);

    // R2
    a_r2_code_in_range: assert property (@(posedge clk) disable iff (rst)
        reason <= 3'd4);

endmodule

bind resp_validity_tracker rvt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .frame_len   (frame_len),
    .reply_ok    (reply_ok),
    .reason      (reason),
    .reply_word  (reply_word)
);

// File: tb/resp_validity_tracker_test.sv
module resp_validity_tracker_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic [4:0]  frame_len = 5'd8;
    logic        rx_valid = 1'b0;
    logic        rx_bit = 1'b0;
    logic        reply_ok;
    logic [2:0]  reason;
    logic [15:0] reply_word;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic        ok;
        logic [2:0]  rsn;
        logic [15:0] word;
        logic        chk_word;
        string       req;
    } exp_t;

    exp_t q[$];

    // bench model state
    int          b_prev_len;
    int          b_cur_len;
    bit          b_have_prev;
    bit          b_have_cur;
    int          s_mode;
    logic [15:0] s_data;
    int          s_n;
    logic        last_ok;
    logic [2:0]  last_rsn;

    always #2 clk = ~clk;

    resp_validity_tracker uut (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_len   (frame_len),
        .rx_valid    (rx_valid),
        .rx_bit      (rx_bit),
        .reply_ok    (reply_ok),
        .reason      (reason),
        .reply_word  (reply_word)
    );

    function automatic logic [3:0] ref_crc(input logic [15:0] d, input int n);
        logic [3:0] c;
        logic       x;
        c = 4'b1010;
        for (int i = n - 1; i >= 0; i--) begin
            x = c[3] ^ d[i];
            c = {c[2:0], 1'b0};
            if (x) c = c ^ 4'b0001;
        end
        return c;
    endfunction

    function automatic logic [15:0] mask_n(input logic [15:0] d, input int n);
        logic [15:0] m;
        m = (n >= 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
        return d & m;
    endfunction

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic model_reset();
        b_prev_len  = 16;
        b_cur_len   = 16;
        b_have_prev = 0;
        b_have_cur  = 0;
        s_mode      = 0;
        s_data      = '0;
        s_n         = 16;
        last_ok     = 1'b0;
        last_rsn    = 3'd1;
    endtask

    task automatic push_expect();
        exp_t e;
        bit pl, cl;
        pl = (b_prev_len == 16);
        cl = (b_cur_len == 16);
        if (!b_have_prev)            begin e.rsn = 3'd1; e.req = "R5"; end
        else if (!pl && cl)          begin e.rsn = 3'd2; e.req = (s_mode == 1) ? "R7" : "R3"; end
        else if (pl && !cl)          begin e.rsn = 3'd3; e.req = "R4"; end
        else if (s_mode == 1)        begin e.rsn = 3'd4; e.req = "R6"; end
        else if (s_mode == 2)        begin e.rsn = 3'd4; e.req = "R8"; end
        else                         begin e.rsn = 3'd0; e.req = (s_mode == 3) ? "R10" : "R6"; end
        e.ok       = (e.rsn == 3'd0);
        e.word     = mask_n(s_data, s_n);
        e.chk_word = b_have_prev;
        q.push_back(e);
    endtask

    task automatic send_bit(input logic b);
        rx_valid = 1'b1;
        rx_bit   = b;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_bit   = 1'b0;
    endtask

    // mode: 0 good, 1 bad check bits, 2 data only, 3 surplus trailing bits
    task automatic send_frame(input int len, input logic [15:0] data, input int mode);
        logic [3:0] c;
        @(negedge clk);
        if (b_have_cur) push_expect();
        frame_start = 1'b1;
        frame_len   = 5'(len);
        @(negedge clk);
        frame_start = 1'b0;
        b_have_prev = b_have_cur;
        b_prev_len  = b_cur_len;
        b_cur_len   = len;
        b_have_cur  = 1;
        s_mode = mode;
        s_data = data;
        s_n    = b_prev_len;
        c = ref_crc(data, s_n);
        if (mode == 1) c = c ^ 4'b0110;
        for (int i = s_n - 1; i >= 0; i--) send_bit(data[i]);
        if (mode != 2)
            for (int i = 3; i >= 0; i--) send_bit(c[i]);
        if (mode == 3) begin
            send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        end
        repeat (2) @(negedge clk);
        // R2: verdict holds through the frame
        check(reply_ok == last_ok && reason == last_rsn, "R2", "hold",
              {reply_ok, reason}, {last_ok, last_rsn});
    endtask

    // monitor: scoreboard pop and compare
    initial begin
        forever begin
            @(posedge clk);
            if (frame_start && !rst) begin
                @(negedge clk);
                if (q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check(reason == e.rsn, e.req, "reason", reason, e.rsn);
                    check(reply_ok == e.ok, "R2", "reply_ok", reply_ok, e.ok);
                    if (e.chk_word)
                        check(reply_word == e.word, "R9", "reply_word", reply_word, e.word);
                    last_ok  = reply_ok;
                    last_rsn = reason;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(reply_ok == 1'b0, "R5", "reset ok", reply_ok, 0);
        check(reason == 3'd1, "R5", "reset reason", reason, 1);
        check(reply_word == 16'h0, "R5", "reset word", reply_word, 0);

        send_frame(8, 16'h00A5, 0);    // first frame: opening changes nothing
        check(reason == 3'd1 && reply_word == 16'h0, "R5", "first open",
              {reason, reply_word}, {3'd1, 16'h0});
        send_frame(8,  16'h003C, 0);   // closes first frame: R5
        send_frame(8,  16'h00C3, 1);   // 8->8 good: R6
        send_frame(12, 16'h005A, 0);   // previous bad check bits: R6
        send_frame(12, 16'h0F0F, 3);   // 8->12 both short: R1
        send_frame(16, 16'h0ABC, 1);   // surplus bits ignored: R10
        send_frame(16, 16'hBEEF, 0);   // 12->16 with bad check: R3, R7
        send_frame(16, 16'h1234, 0);   // 16->16
        send_frame(8,  16'hFACE, 0);   // 16->16 good
        send_frame(8,  16'h0077, 0);   // 16->8: R4
        send_frame(15, 16'h0081, 2);   // 8->8 good
        send_frame(15, 16'h6D2B, 0);   // previous cut short: R8
        send_frame(16, 16'h0000, 0);   // 15->15 good, n=15
        send_frame(8,  16'h5555, 0);   // 15->16: R3

        // reset mid traffic
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        q.delete();
        model_reset();
        @(negedge clk);
        check(reason == 3'd1 && !reply_ok && reply_word == 16'h0, "R5", "mid reset",
              {reply_ok, reason, reply_word}, {1'b0, 3'd1, 16'h0});
        send_frame(16, 16'h1111, 0);
        send_frame(16, 16'h2468, 0);   // closes first: R5
        send_frame(8,  16'h9AC1, 0);   // 16->16 good
        send_frame(8,  16'h0033, 0);   // 16->8: R4
        send_frame(8,  16'h0000, 0);   // closing frame
        repeat (4) @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule